// File: doc/BRIEF.md
# Double-Buffered SPI Image Store

This block holds two equal image buffers between a byte stream arriving from an SPI receiver and a parallel pixel bus feeding a display controller. At any moment one buffer is the receive side and the other is the transmit side, and either physical buffer can take either role. Incoming bytes always land in the receive-side buffer; the sender never names a buffer. When a whole frame has been written, the roles exchange, so the freshly written image becomes the one that streams out.

Output is gated by a host command. Until the parallel-video command enables streaming, nothing leaves the block. Once enabled, the setting stays, and every frame that is swapped in is streamed once with no further command. Clearing the setting stops output at the next frame boundary. If a new frame completes while the transmit side is still mid-frame, the swap is held back and the block reports busy. Bytes that arrive while it is busy are discarded and counted.

Top module: `pp_frame_buffer`

## Requirements
- R1: After reset buffer 0 is the transmit side, streaming is disabled, no swap is pending, `busy` and `px_valid` are low and the drop counter reads 0.
- R2: Each accepted byte is stored in the receive-side buffer at consecutive addresses starting at 0; the sender has no way to choose the buffer.
- R3: When the byte at address FRAME_WORDS-1 is accepted while the output is idle, `stat_active` flips at that same clock edge.
- R4: `px_valid` stays low until a command with opcode 0xC3 and `cmd_val` bit 0 equal to 1 is received; commands with any other opcode leave the enable unchanged.
- R5: While enabled, each swapped-in frame streams exactly once without any new command: words in address order, `px_last` high only on the last word, advancing only when `px_valid` and `px_ready` are both high, and `px_data` held steady while stalled.
- R6: Opcode 0xC3 with bit 0 equal to 0 clears the enable; a frame already streaming completes in full and no later frame starts.
- R7: A frame that completes while an output frame is in progress, or in the same cycle that an output frame starts, sets `stat_swap_pending` and `busy`; the swap happens once that output frame's last word has been taken, and the new frame then streams.
- R8: While `busy` is high, incoming bytes are discarded without changing either buffer, and `ovf_count` increases by one per discarded byte, saturating at its maximum.
- R9: A byte marked with `rx_sof` is written to address 0 and the following bytes continue from there, abandoning any partial frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present |
| rx_sof | input | 1 | Present byte is the first of a frame |
| rx_data | input | DATA_W | Received byte |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 8 | Command opcode |
| cmd_val | input | 8 | Command argument |
| px_valid | output | 1 | Output word is valid |
| px_ready | input | 1 | Downstream accepts the word |
| px_data | output | DATA_W | Output word |
| px_last | output | 1 | Last word of the output frame |
| stat_active | output | 1 | Index of the transmit-side buffer |
| stat_enable | output | 1 | Streaming enable state |
| stat_swap_pending | output | 1 | A completed frame waits for the swap |
| busy | output | 1 | Incoming bytes are being discarded |
| ovf_count | output | OVF_W | Count of discarded bytes |

## Verification
The delicate coincidence is a frame completing in exactly the cycle where the reader would begin streaming a frame already swapped in. The bench provokes it by leaving a frame loaded with streaming disabled, then issuing the enable command alongside the second-to-last byte of the next frame so that the last byte lands in the first enabled cycle. It judges the outcome by seeing the swap held pending, the older frame streamed intact, and only then the newer frame following it. A second coincidence, the swap landing on the cycle the last output word is taken, is checked by streaming two back-to-back frames under backpressure.

// File: rtl/pp_fb_pkg.sv
package pp_fb_pkg;
  localparam logic [7:0] CMD_PVIDEO = 8'hC3;
  localparam int         NUM_BANKS  = 2;
endpackage

// File: rtl/pp_fb_bank.sv
module pp_fb_bank #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic          wsel,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rsel,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  import pp_fb_pkg::*;

  logic [DW-1:0] bank_rd [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    logic          bank_we;

    assign bank_we = we && (wsel == b[0]);

    always_ff @(posedge clk) begin
      if (bank_we) begin
        mem[waddr] <= wdata;
      end
    end

    assign bank_rd[b] = mem[raddr];
  end

  assign rdata = rsel ? bank_rd[1] : bank_rd[0];
endmodule

// File: rtl/pp_fb_wr.sv
module pp_fb_wr #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int OVF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             busy_i,
  output logic             we_o,
  output logic [AW-1:0]    waddr_o,
  output logic             frame_done_o,
  output logic [OVF_W-1:0] ovf_o
);
  localparam logic [AW-1:0]    LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [OVF_W-1:0] OVF_MAX   = '1;

  logic [AW-1:0]    wr_addr_q, wr_addr_d;
  logic [OVF_W-1:0] ovf_q, ovf_d;
  logic             ovf_inc;

  always_comb begin
    we_o         = rx_valid && !busy_i;
    waddr_o      = rx_sof ? '0 : wr_addr_q;
    frame_done_o = we_o && (waddr_o == LAST_ADDR);
    wr_addr_d    = wr_addr_q;
    if (we_o) begin
      wr_addr_d = frame_done_o ? '0 : waddr_o + 1'b1;
    end
    ovf_inc = rx_valid && busy_i && (ovf_q != OVF_MAX);
    ovf_d   = ovf_inc ? ovf_q + 1'b1 : ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
      ovf_q     <= '0;
    end else begin
      wr_addr_q <= wr_addr_d;
      ovf_q     <= ovf_d;
    end
  end

  assign ovf_o = ovf_q;

  p_drop_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && busy_i && ovf_q != OVF_MAX) |=> (ovf_q == $past(ovf_q) + 1'b1));

  p_drop_keeps_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i) |=> (wr_addr_q == $past(wr_addr_q)));
endmodule

// File: rtl/pp_fb_rd.sv
module pp_fb_rd #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          px_ready,
  output logic          px_valid,
  output logic          px_last,
  output logic [AW-1:0] raddr_o,
  output logic          run_o
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic          run_q, run_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          beat;

  always_comb begin
    beat   = run_q && px_ready;
    run_d  = run_q;
    addr_d = addr_q;
    if (start_i) begin
      run_d  = 1'b1;
      addr_d = '0;
    end else if (beat) begin
      if (addr_q == LAST_ADDR) begin
        run_d  = 1'b0;
        addr_d = '0;
      end else begin
        addr_d = addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      run_q  <= run_d;
      addr_q <= addr_d;
    end
  end

  assign px_valid = run_q;
  assign px_last  = run_q && (addr_q == LAST_ADDR);
  assign raddr_o  = addr_q;
  assign run_o    = run_q;

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !px_ready) |=> (px_valid && $stable(raddr_o)));

  p_last_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && px_last && px_ready) |=> !px_valid);
endmodule

// File: rtl/pp_fb_role.sv
module pp_fb_role (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_op,
  input  logic [7:0] cmd_val,
  input  logic       frame_done_i,
  input  logic       rd_run_i,
  output logic       active_o,
  output logic       en_o,
  output logic       pending_o,
  output logic       start_o
);
  import pp_fb_pkg::*;

  logic active_q, active_d;
  logic en_q, en_d;
  logic pend_q, pend_d;
  logic loaded_q, loaded_d;
  logic swap_go;

  always_comb begin
    start_o  = !rd_run_i && loaded_q && en_q;
    swap_go  = (frame_done_i || pend_q) && !rd_run_i && !start_o;
    active_d = active_q;
    loaded_d = loaded_q;
    pend_d   = pend_q;
    en_d     = en_q;
    if (cmd_valid && (cmd_op == CMD_PVIDEO)) begin
      en_d = cmd_val[0];
    end
    if (swap_go) begin
      active_d = !active_q;
      loaded_d = 1'b1;
      pend_d   = 1'b0;
    end else begin
      if (frame_done_i) begin
        pend_d = 1'b1;
      end
      if (start_o) begin
        loaded_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      en_q     <= 1'b0;
      pend_q   <= 1'b0;
      loaded_q <= 1'b0;
    end else begin
      active_q <= active_d;
      en_q     <= en_d;
      pend_q   <= pend_d;
      loaded_q <= loaded_d;
    end
  end

  assign active_o  = active_q;
  assign en_o      = en_q;
  assign pending_o = pend_q;

  p_swap_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q != $past(active_q)) |-> !$past(rd_run_i));

  p_pending_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && rd_run_i) |=> (active_q == $past(active_q)));
endmodule

// File: rtl/pp_frame_buffer.sv
module pp_frame_buffer #(
  parameter int DATA_W      = 8,
  parameter int FRAME_WORDS = 16,
  parameter int OVF_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [7:0]        cmd_val,
  output logic              px_valid,
  input  logic              px_ready,
  output logic [DATA_W-1:0] px_data,
  output logic              px_last,
  output logic              stat_active,
  output logic              stat_enable,
  output logic              stat_swap_pending,
  output logic              busy,
  output logic [OVF_W-1:0]  ovf_count
);
  localparam int AW = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;

  logic          we;
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  logic          frame_done;
  logic          rd_run;
  logic          rd_start;
  logic          active;
  logic          en;
  logic          pending;

  pp_fb_wr #(.DEPTH(FRAME_WORDS), .AW(AW), .OVF_W(OVF_W)) u_wr (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_sof       (rx_sof),
    .busy_i       (pending),
    .we_o         (we),
    .waddr_o      (waddr),
    .frame_done_o (frame_done),
    .ovf_o        (ovf_count)
  );

  pp_fb_role u_role (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_val      (cmd_val),
    .frame_done_i (frame_done),
    .rd_run_i     (rd_run),
    .active_o     (active),
    .en_o         (en),
    .pending_o    (pending),
    .start_o      (rd_start)
  );

  pp_fb_rd #(.DEPTH(FRAME_WORDS), .AW(AW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (rd_start),
    .px_ready (px_ready),
    .px_valid (px_valid),
    .px_last  (px_last),
    .raddr_o  (raddr),
    .run_o    (rd_run)
  );

  pp_fb_bank #(.DW(DATA_W), .DEPTH(FRAME_WORDS), .AW(AW)) u_bank (
    .clk   (clk),
    .we    (we),
    .wsel  (!active),
    .waddr (waddr),
    .wdata (rx_data),
    .rsel  (active),
    .raddr (raddr),
    .rdata (px_data)
  );

  assign stat_active       = active;
  assign stat_enable       = en;
  assign stat_swap_pending = pending;
  assign busy              = pending;

  p_no_stream_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(px_valid) |-> $past(en));

  p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !px_ready) |=> $stable(px_data));
endmodule

// File: tb/pp_frame_buffer_tb.sv
`timescale 1ns/1ps
module pp_frame_buffer_tb;
  localparam int N  = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rx_valid, rx_sof;
  logic [DW-1:0] rx_data;
  logic          cmd_valid;
  logic [7:0]    cmd_op, cmd_val;
  logic          px_valid, px_ready, px_last;
  logic [DW-1:0] px_data;
  logic          stat_active, stat_enable, stat_swap_pending, busy;
  logic [7:0]    ovf_count;

  int total = 0;
  int bad   = 0;
  logic exp_act;

  always #10 clk = ~clk;

  pp_frame_buffer #(.DATA_W(DW), .FRAME_WORDS(N), .OVF_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_data(rx_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_val(cmd_val),
    .px_valid(px_valid), .px_ready(px_ready), .px_data(px_data), .px_last(px_last),
    .stat_active(stat_active), .stat_enable(stat_enable),
    .stat_swap_pending(stat_swap_pending), .busy(busy), .ovf_count(ovf_count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input logic sof);
    rx_valid = 1'b1; rx_data = d; rx_sof = sof;
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] base, input int count);
    for (int i = 0; i < count; i++) begin
      send_byte(base + 8'(i), i == 0);
    end
  endtask

  task automatic command(input logic [7:0] op, input logic [7:0] val);
    cmd_valid = 1'b1; cmd_op = op; cmd_val = val;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic read_frame(input logic [7:0] base, input string req);
    bit data_ok = 1'b1;
    bit last_ok = 1'b1;
    int bad_act = 0;
    int bad_exp = 0;
    px_ready = 1'b1;
    for (int i = 0; i < N; i++) begin
      int g = 0;
      while (!px_valid && g < 60) begin
        @(negedge clk);
        g++;
      end
      if (!px_valid || px_data != base + 8'(i)) begin
        if (data_ok) begin bad_act = px_data; bad_exp = base + 8'(i); end
        data_ok = 1'b0;
      end
      if (px_last != (i == N - 1)) last_ok = 1'b0;
      @(negedge clk);
    end
    check(data_ok, {req, " stream data"}, bad_act, bad_exp);
    check(last_ok, {req, " px_last marks final word"}, 0, 1);
  endtask

  task automatic idle_window(input int cycles, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      if (px_valid) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, {req, " no output while disabled"}, seen, 0);
  endtask

  task automatic t_reset;
    check(stat_active == 1'b0, "R1 active buffer", stat_active, 0);
    check(stat_enable == 1'b0, "R1 enable", stat_enable, 0);
    check(!stat_swap_pending && !busy, "R1 pending/busy", {stat_swap_pending, busy}, 0);
    check(!px_valid, "R1 px_valid", px_valid, 0);
    check(ovf_count == 0, "R1 ovf_count", ovf_count, 0);
  endtask

  task automatic t_first_frame_gated;
    send_frame(8'h10, N);
    exp_act = ~exp_act;
    check(stat_active == exp_act, "R3 swap after full frame", stat_active, exp_act);
    idle_window(20, "R4");
    command(8'hC2, 8'h01);
    check(stat_enable == 1'b0, "R4 other opcode ignored", stat_enable, 0);
    idle_window(5, "R4");
    command(8'hC3, 8'h01);
    check(stat_enable == 1'b1, "R4 enable set", stat_enable, 1);
    read_frame(8'h10, "R2");
    check(!px_valid, "R5 streamed once", px_valid, 0);
    command(8'h00, 8'h00);
    check(stat_enable == 1'b1, "R4 other opcode leaves enable", stat_enable, 1);
  endtask

  task automatic t_sticky;
    send_frame(8'h40, N);
    exp_act = ~exp_act;
    check(stat_active == exp_act, "R3 second swap", stat_active, exp_act);
    read_frame(8'h40, "R5");
  endtask

  task automatic t_overlap_drop;
    px_ready = 1'b0;
    send_frame(8'h70, N);
    exp_act = ~exp_act;
    @(negedge clk);
    check(px_valid && px_data == 8'h70, "R5 stalled first word", px_data, 8'h70);
    send_frame(8'hA0, N);
    check(stat_swap_pending && busy, "R7 pending while streaming", {stat_swap_pending, busy}, 3);
    check(stat_active == exp_act, "R7 no swap mid frame", stat_active, exp_act);
    send_byte(8'hEE, 1'b1);
    send_byte(8'hEE, 1'b0);
    send_byte(8'hEE, 1'b0);
    check(ovf_count == 3, "R8 dropped bytes counted", ovf_count, 3);
    check(px_data == 8'h70, "R5 data held under stall", px_data, 8'h70);
    read_frame(8'h70, "R7 older frame");
    exp_act = ~exp_act;
    read_frame(8'hA0, "R8 newer frame intact");
    check(stat_active == exp_act, "R7 swap after output frame", stat_active, exp_act);
    check(!busy, "R7 busy cleared", busy, 0);
  endtask

  task automatic t_sof_restart;
    send_frame(8'hFF, 5);
    check(stat_active == exp_act, "R9 partial frame no swap", stat_active, exp_act);
    send_frame(8'h30, N);
    exp_act = ~exp_act;
    check(stat_active == exp_act, "R9 restart swap", stat_active, exp_act);
    read_frame(8'h30, "R9");
  endtask

  task automatic t_disable;
    px_ready = 1'b0;
    send_frame(8'hC0, N);
    exp_act = ~exp_act;
    @(negedge clk);
    command(8'hC3, 8'h00);
    check(stat_enable == 1'b0, "R6 enable cleared", stat_enable, 0);
    check(px_valid, "R6 frame continues", px_valid, 1);
    read_frame(8'hC0, "R6 no truncation");
    send_frame(8'h50, N);
    exp_act = ~exp_act;
    check(stat_active == exp_act, "R6 swap while disabled", stat_active, exp_act);
    idle_window(20, "R6");
  endtask

  task automatic t_collision;
    px_ready = 1'b0;
    for (int i = 0; i < N - 2; i++) send_byte(8'hE0 + 8'(i), i == 0);
    cmd_valid = 1'b1; cmd_op = 8'hC3; cmd_val = 8'h01;
    send_byte(8'hE0 + 8'(N - 2), 1'b0);
    cmd_valid = 1'b0;
    send_byte(8'hE0 + 8'(N - 1), 1'b0);
    check(stat_swap_pending, "R7 start and completion collide", stat_swap_pending, 1);
    check(px_valid && px_data == 8'h50, "R7 older frame starts", px_data, 8'h50);
    read_frame(8'h50, "R7 collide older");
    exp_act = ~exp_act;
    read_frame(8'hE0, "R7 collide newer");
    check(stat_active == exp_act, "R7 final active", stat_active, exp_act);
    check(stat_enable, "R5 enable still set", stat_enable, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_valid = 1'b0; rx_sof = 1'b0; rx_data = '0;
    cmd_valid = 1'b0; cmd_op = '0; cmd_val = '0; px_ready = 1'b1;
    exp_act = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_first_frame_gated;
    t_sticky;
    t_overlap_drop;
    t_sof_restart;
    t_disable;
    t_collision;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule